// File: doc/BRIEF.md
# Vectored Level-Priority Interrupt Controller

This controller collects 63 active-high, level-sensitive request lines, numbered 1 to 63. It presents the most urgent request that is still eligible to a processor as a 3-bit interrupt level. Each source has a 64-bit mask bit. Sources 1 to 56 also have a programmable control byte that holds a level and a priority within that level. Sources 57 to 63 have a fixed level and cannot be reprogrammed.

Software reaches the mask words and the control bytes through a plain register bus. Writes are single-cycle strobes. Reads are combinational from the address. When the processor takes an interrupt it presents an acknowledge that carries a level. The block answers in the same cycle with a vector number for the source that currently wins at that level, or with a spurious vector.

Arbitration is registered once per level. A change on a request line or in a register shows up on the level output one clock edge after the change is visible to the arbiter.

Top module: `vlp_intc`

## Requirements
- R1: Out of reset, both mask words read 0xFFFFFFFF, every programmable control byte reads 0, and `irq_level` is 0.
- R2: Register map (7-bit address):
  - Address 0 is the low mask word (sources 0..31) and address 1 is the high mask word (sources 32..63).
  - Address 64+n is the control byte of source n. Bits 5:3 hold the level and bits 2:0 hold the priority. Bits 7:6 read 0.
  - Addresses 2..63 and the control byte of index 0 read 0, and writes to them are ignored.
- R3: The mask bit of source n is bit n of the 64-bit value {high word, low word}. A source whose mask bit is 1 is never presented, and clearing the bit enables it.
- R4: While bit 0 of the low mask word is 1, no source is presented and every acknowledge returns the spurious vector.
- R5: A source whose level is 0 is never presented, even when it is requested and unmasked.
- R6: `irq_level` is the highest level among requested, unmasked sources with a nonzero level, or 0 when there is none.
- R7: Within one level, the source with the highest priority wins.
- R8: Sources 57..63 have the fixed level n-56 and priority 0. Their control byte reads (n-56)<<3, and writes to it are ignored.
- R9: The acknowledge response is combinational:
  - When `ack_valid` is high, `ack_vector` is 64 + n, where n is the current winner at `ack_level`.
  - The response is the spurious vector 24 when that level has no winner, when `ack_level` is 0, or when `ack_valid` is low.
- R10: A request change made before clock edge k changes `irq_level` at edge k. A register write captured at edge k changes `irq_level` at edge k+1.
- R11: Requests are level-sensitive. A source stops being presented one edge after its request line falls, with no clearing action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 7 | Register address |
| bus_wdata | input | 32 | Write data (control bytes use bits 5:0) |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_src | input | 63 | Request lines; bit n is source n (n = 1..63) |
| irq_level | output | 3 | Winning level, 0 when idle |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_level | input | 3 | Level being acknowledged |
| ack_vector | output | 8 | Vector number for the acknowledge |

## Verification
The assertions assume several things about the inputs:
- `bus_wr` and `bus_addr` are known on every clock edge.
- `ack_level` is meaningful only while `ack_valid` is high.
- Inputs are held quiet during reset.

The stimulus drives all inputs after the falling edge and lowers `bus_wr` after a single cycle. It never acknowledges with an unknown level. It gives every enabled source a distinct level and priority pair, so no result depends on how ties are broken.

// File: rtl/vlp_intc_pkg.sv
package vlp_intc_pkg;
  localparam int LVL_W   = 3;
  localparam int PRI_W   = 3;
  localparam int CTRL_W  = LVL_W + PRI_W;
  localparam int NUM_LVL = (1 << LVL_W) - 1;
  localparam int WORD_W  = 32;
endpackage

// File: rtl/vlp_intc_regs.sv
module vlp_intc_regs
  import vlp_intc_pkg::*;
#(
  parameter int NSRC   = 63,
  parameter int NPROG  = 56,
  parameter int ADDR_W = 7,
  localparam int NWORDS = (NSRC + WORD_W) / WORD_W,
  localparam int MW     = NWORDS * WORD_W,
  localparam int IDX_W  = ADDR_W - 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [WORD_W-1:0]              wdata,
  output logic [WORD_W-1:0]              rdata,
  output logic [MW-1:0]                  mask,
  output logic [NSRC:0][LVL_W-1:0]       lvl,
  output logic [NSRC:0][PRI_W-1:0]       pri
);
  logic              ctrl_hit;
  logic [IDX_W-1:0]  cidx;
  logic [MW-1:0]     mask_q;
  logic [CTRL_W-1:0] ctrl_q [1:NPROG];

  assign ctrl_hit = addr[ADDR_W-1];
  assign cidx     = addr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      for (int i = 1; i <= NPROG; i++) ctrl_q[i] <= '0;
    end else if (wr) begin
      if (ctrl_hit) begin
        if (int'(cidx) >= 1 && int'(cidx) <= NPROG)
          ctrl_q[cidx] <= wdata[CTRL_W-1:0];
      end else begin
        for (int w = 0; w < NWORDS; w++)
          if (int'(cidx) == w) mask_q[w*WORD_W +: WORD_W] <= wdata;
      end
    end
  end

  genvar s;
  generate
    for (s = 0; s <= NSRC; s++) begin : g_src
      if (s == 0) begin : g_none
        assign lvl[s] = '0;
        assign pri[s] = '0;
      end else if (s <= NPROG) begin : g_prog
        assign lvl[s] = ctrl_q[s][CTRL_W-1:PRI_W];
        assign pri[s] = ctrl_q[s][PRI_W-1:0];
      end else begin : g_fixed
        assign lvl[s] = LVL_W'(s - NPROG);
        assign pri[s] = '0;
      end
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (ctrl_hit) begin
      for (int i = 1; i <= NSRC; i++)
        if (int'(cidx) == i) rdata[CTRL_W-1:0] = {lvl[i], pri[i]};
    end else begin
      for (int w = 0; w < NWORDS; w++)
        if (int'(cidx) == w) rdata = mask_q[w*WORD_W +: WORD_W];
    end
  end

  assign mask = mask_q;
endmodule

// File: rtl/vlp_intc_level_arb.sv
module vlp_intc_level_arb
  import vlp_intc_pkg::*;
#(
  parameter int NSRC  = 63,
  parameter int LEVEL = 1,
  localparam int IDX_W = $clog2(NSRC + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC:0]            elig,
  input  logic [NSRC:0][LVL_W-1:0] lvl,
  input  logic [NSRC:0][PRI_W-1:0] pri,
  output logic                     win_valid,
  output logic [IDX_W-1:0]         win_src
);
  logic             found;
  logic [PRI_W-1:0] best_p;
  logic [IDX_W-1:0] best_s;

  always_comb begin
    found  = 1'b0;
    best_p = '0;
    best_s = '0;
    for (int s = 1; s <= NSRC; s++) begin
      if (elig[s] && lvl[s] == LVL_W'(LEVEL) && (!found || pri[s] > best_p)) begin
        found  = 1'b1;
        best_p = pri[s];
        best_s = IDX_W'(s);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_valid <= 1'b0;
      win_src   <= '0;
    end else begin
      win_valid <= found;
      win_src   <= best_s;
    end
  end
endmodule

// File: rtl/vlp_intc.sv
module vlp_intc
  import vlp_intc_pkg::*;
#(
  parameter int NSRC     = 63,
  parameter int NPROG    = 56,
  parameter int ADDR_W   = 7,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int SPUR_VEC = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NSRC:1]     irq_src,
  output logic [2:0]        irq_level,
  input  logic              ack_valid,
  input  logic [2:0]        ack_level,
  output logic [VEC_W-1:0]  ack_vector
);
  localparam int NWORDS = (NSRC + WORD_W) / WORD_W;
  localparam int MW     = NWORDS * WORD_W;
  localparam int IDX_W  = $clog2(NSRC + 1);

  logic [MW-1:0]                  mask_q;
  logic [NSRC:0][LVL_W-1:0]       lvl;
  logic [NSRC:0][PRI_W-1:0]       pri;
  logic [NSRC:0]                  elig;
  logic [NUM_LVL:0]               lv_valid;
  logic [NUM_LVL:0][IDX_W-1:0]    lv_src;

  vlp_intc_regs #(.NSRC(NSRC), .NPROG(NPROG), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .mask(mask_q),
    .lvl(lvl), .pri(pri)
  );

  always_comb begin
    elig = '0;
    for (int s = 1; s <= NSRC; s++)
      elig[s] = irq_src[s] && !mask_q[s] && !mask_q[0] && (lvl[s] != '0);
  end

  assign lv_valid[0] = 1'b0;
  assign lv_src[0]   = '0;

  genvar l;
  generate
    for (l = 1; l <= NUM_LVL; l++) begin : g_lvl
      vlp_intc_level_arb #(.NSRC(NSRC), .LEVEL(l)) u_arb (
        .clk(clk), .rst_n(rst_n), .elig(elig), .lvl(lvl), .pri(pri),
        .win_valid(lv_valid[l]), .win_src(lv_src[l])
      );
    end
  endgenerate

  always_comb begin
    irq_level = '0;
    for (int i = 1; i <= NUM_LVL; i++)
      if (lv_valid[i]) irq_level = 3'(i);
  end

  always_comb begin
    ack_vector = VEC_W'(SPUR_VEC);
    if (ack_valid && lv_valid[ack_level])
      ack_vector = VEC_W'(VEC_BASE) + VEC_W'(lv_src[ack_level]);
  end
endmodule

// File: rtl/vlp_intc_chk.sv
module vlp_intc_chk #(
  parameter int NSRC     = 63,
  parameter int MW       = 64,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int SPUR_VEC = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [MW-1:0]    mask_q,
  input logic [NSRC:0]    elig,
  input logic [2:0]       irq_level,
  input logic             ack_valid,
  input logic [2:0]       ack_level,
  input logic [VEC_W-1:0] ack_vector
);
  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr) |-> $stable(mask_q));

  p_mask_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mask_q[0]) |-> (irq_level == 3'd0));

  p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(elig) == '0) |-> (irq_level == 3'd0));

  p_busy_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(elig) != '0) |-> (irq_level != 3'd0));

  p_no_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid |-> (ack_vector == VEC_W'(SPUR_VEC)));

  p_top_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_level == irq_level && irq_level != 3'd0)
      |-> (ack_vector != VEC_W'(SPUR_VEC)));

  p_vec_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_vector != VEC_W'(SPUR_VEC))
      |-> (ack_vector > VEC_W'(VEC_BASE) && ack_vector <= VEC_W'(VEC_BASE + NSRC)));
endmodule

bind vlp_intc vlp_intc_chk #(
  .NSRC(NSRC), .MW(MW), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .SPUR_VEC(SPUR_VEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .mask_q(mask_q), .elig(elig),
  .irq_level(irq_level), .ack_valid(ack_valid), .ack_level(ack_level),
  .ack_vector(ack_vector)
);

// File: tb/vlp_intc_tb.sv
module vlp_intc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:1] irq_src = '0;
  logic [2:0]  irq_level;
  logic        ack_valid = 1'b0;
  logic [2:0]  ack_level = '0;
  logic [7:0]  ack_vector;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  vlp_intc u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src),
    .irq_level(irq_level), .ack_valid(ack_valid), .ack_level(ack_level),
    .ack_vector(ack_vector)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ack(input logic [2:0] lv, output logic [7:0] v);
    ack_valid = 1'b1; ack_level = lv;
    #1 v = ack_vector;
    ack_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq_level", 32'(irq_level), 0);
    rd(7'd0, d);  check("R1 low mask", d, 32'hFFFF_FFFF);
    rd(7'd1, d);  check("R1 high mask", d, 32'hFFFF_FFFF);
    rd(7'd69, d); check("R1 ctrl src5", d, 0);
    rd(7'd121, d); check("R8 fixed src57", d, 32'h08);
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    wr(7'd84, 32'hFF);
    rd(7'd84, d); check("R2 ctrl bits 7:6", d, 32'h3F);
    wr(7'd84, 32'h00);
    wr(7'd5, 32'hDEAD_BEEF);
    rd(7'd5, d);  check("R2 unused addr", d, 0);
    wr(7'd64, 32'h3F);
    rd(7'd64, d); check("R2 ctrl index 0", d, 0);
    wr(7'd69, 32'h1A);
    wr(7'd104, 32'h1D);
    wr(7'd74, 32'h29);
    rd(7'd104, d); check("R2 ctrl src40", d, 32'h1D);
    wr(7'd0, 32'h0);
    wr(7'd1, 32'h0);
    rd(7'd1, d); check("R2 high mask write", d, 0);
  endtask

  task automatic t_level_zero;
    irq_src[20] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R5 level0 source ignored", 32'(irq_level), 0);
    irq_src[20] = 1'b0;
  endtask

  task automatic t_arbitrate;
    logic [7:0] v;
    irq_src[5] = 1'b1;
    @(negedge clk);
    check("R6 single source level", 32'(irq_level), 3);
    ack(3'd3, v); check("R9 vector src5", 32'(v), 69);
    irq_src[40] = 1'b1;
    @(negedge clk);
    ack(3'd3, v); check("R7 higher priority wins", 32'(v), 104);
    irq_src[10] = 1'b1;
    @(negedge clk);
    check("R6 highest level", 32'(irq_level), 5);
    ack(3'd5, v); check("R9 vector level5", 32'(v), 74);
    ack(3'd3, v); check("R9 lower level winner", 32'(v), 104);
    ack(3'd2, v); check("R9 empty level spurious", 32'(v), 24);
    ack(3'd0, v); check("R9 level0 spurious", 32'(v), 24);
    #1 check("R9 no ack spurious", 32'(ack_vector), 24);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    wr(7'd1, 32'h100);
    @(negedge clk);
    ack(3'd3, v); check("R3 high mask blocks src40", 32'(v), 69);
    wr(7'd0, 32'h400);
    @(negedge clk);
    check("R3 low mask blocks src10", 32'(irq_level), 3);
  endtask

  task automatic t_mask_all;
    logic [7:0] v;
    wr(7'd0, 32'h401);
    @(negedge clk);
    check("R4 mask-all level", 32'(irq_level), 0);
    ack(3'd3, v); check("R4 mask-all vector", 32'(v), 24);
    wr(7'd0, 32'h400);
    @(negedge clk);
    check("R4 release", 32'(irq_level), 3);
  endtask

  task automatic t_fixed;
    logic [31:0] d;
    logic [7:0] v;
    wr(7'd124, 32'h3F);
    rd(7'd124, d); check("R8 fixed ctrl read-only", d, 32'h20);
    irq_src[60] = 1'b1;
    @(negedge clk);
    check("R8 fixed level", 32'(irq_level), 4);
    ack(3'd4, v); check("R8 fixed vector", 32'(v), 124);
    irq_src[60] = 1'b0;
  endtask

  task automatic t_timing;
    irq_src = '0;
    @(negedge clk); @(negedge clk);
    check("R11 all dropped", 32'(irq_level), 0);
    irq_src[5] = 1'b1;
    #1 check("R10 before edge", 32'(irq_level), 0);
    @(negedge clk);
    check("R10 after one edge", 32'(irq_level), 3);
    wr(7'd69, 32'h32);
    check("R10 write edge not yet", 32'(irq_level), 3);
    @(negedge clk);
    check("R10 write visible", 32'(irq_level), 6);
    irq_src[5] = 1'b0;
    @(negedge clk);
    check("R11 drop clears", 32'(irq_level), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_level_zero();
    t_arbitrate();
    t_mask();
    t_mask_all();
    t_fixed();
    t_timing();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule